// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block keeps the status of one host-side USB transfer descriptor and updates it after every bus transaction on that descriptor. The state is a small retry counter and four flags: Active, Halted, Babble and Buffer Error. A separate illegal-configuration flag is also held. Software, or a fetch engine, loads the descriptor through a load port. The bus engine then reports each transaction with a one-cycle outcome strobe and an outcome code. Alongside the strobe it gives the endpoint speed and whether the descriptor sits in the asynchronous schedule.

The retry counter only counts when it is loaded with a non-zero value. A value of zero means retries are unlimited. Only transaction errors use up a retry. A clean transaction reloads the counter to its maximum, but only on high-speed endpoints or in the asynchronous schedule. When the last retry is used up, the descriptor halts and a one-cycle error-interrupt pulse is raised. The block also turns the stored 2-bit token code into the PID byte that the token generator sends.

Top module: `qtd_status_updater`

## Requirements
- R1: Reset clears the counter, the token code and every flag to zero, and err_irq is 0.
- R2: A load pulse sets the counter, Active and the token code from the load inputs, and clears Halted, Babble, Buffer Error and Illegal. A load wins over an outcome strobe in the same cycle, and that strobe has no effect.
- R3: pid_byte is E1h for token code 00 (OUT), 69h for 01 (IN) and 2Dh for 10 (SETUP). It is 00h for the reserved code 11.
- R4: Outcome code 1 (transaction error) decrements a counter that is 2 or 3. With a counter of 0 it changes nothing, so retries are unlimited.
- R5: A transaction error with the counter at 1 sets the counter to 0, sets Halted and clears Active. err_irq is 1 in exactly the one cycle after that update.
- R6: Outcome 2 (STALL) sets Halted and clears Active. Outcome 3 (babble) does the same and also sets Babble. Neither changes the counter.
- R7: Outcome 4 (buffer overrun/underrun) sets Buffer Error without changing the counter or Active. Buffer Error then stays set until the next load.
- R8: Outcome 0 (success) reloads the counter to 3 when the speed is high (speed code 10) or async_sched is 1, and the counter is not 0. Otherwise the counter is unchanged.
- R9: Whenever Halted is 1, Active is 0.
- R10: Outcome strobes while Active is 0 leave all state unchanged. Outcome codes 5 to 7 also change nothing.
- R11: An outcome strobe on an active descriptor whose token code is 11 sets Illegal and Halted and clears Active, leaving the counter and the other flags unchanged. The same happens when the counter is 0 and the speed code is not 10 (00 full, 01 low, 11 treated as not high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load strobe |
| ld_count | input | 2 | Retry counter value to load |
| ld_active | input | 1 | Active value to load |
| ld_token | input | 2 | Token code to load |
| ev_valid | input | 1 | Outcome strobe, one cycle per transaction |
| ev_code | input | 3 | Outcome: 0 success, 1 transaction error, 2 STALL, 3 babble, 4 buffer error |
| ep_speed | input | 2 | Endpoint speed: 00 full, 01 low, 10 high |
| async_sched | input | 1 | Descriptor belongs to the asynchronous schedule |
| err_cnt | output | 2 | Retry counter |
| active | output | 1 | Active flag |
| halted | output | 1 | Halted flag |
| babble | output | 1 | Babble flag |
| buf_err | output | 1 | Buffer Error flag |
| illegal_cfg | output | 1 | Illegal configuration flag |
| err_irq | output | 1 | One-cycle error-interrupt pulse |
| pid_byte | output | 8 | PID byte for the stored token code |

## Verification
On every cycle the assertions check the following rules:
- Halted never coexists with Active.
- A zero counter never moves except on a load.
- STALL, babble and buffer outcomes leave the counter alone.
- Buffer Error stays set once set.
- The interrupt is a single-cycle pulse that only appears with a halted, exhausted counter.
- An inactive descriptor holds its state.

Some behaviour can only be shown by the bench's scenarios:
- The exact counter value after each outcome under every mix of speed and schedule.
- The three-step walk down to exhaustion.
- Load priority over a same-cycle strobe.
- The PID byte values.

// File: rtl/qtd_pkg.sv
package qtd_pkg;

   typedef enum logic [2:0] {
      OUT_OK     = 3'd0,
      OUT_XERR   = 3'd1,
      OUT_STALL  = 3'd2,
      OUT_BABBLE = 3'd3,
      OUT_BUFERR = 3'd4
   } outcome_e;

   localparam logic [1:0] SPD_FULL = 2'b00;
   localparam logic [1:0] SPD_LOW  = 2'b01;
   localparam logic [1:0] SPD_HIGH = 2'b10;

   localparam logic [1:0] TOK_OUT   = 2'b00;
   localparam logic [1:0] TOK_IN    = 2'b01;
   localparam logic [1:0] TOK_SETUP = 2'b10;
   localparam logic [1:0] TOK_RSV   = 2'b11;

endpackage

// File: rtl/qtd_token_map.sv
module qtd_token_map #(
   parameter int TOK_W = 2,
   parameter int PID_W = 8
) (
   input  logic [TOK_W-1:0] tok,
   output logic [PID_W-1:0] pid
);
   import qtd_pkg::*;

   localparam int NIB_W = PID_W / 2;

   if (PID_W != 8) begin : g_bad_pid
      $error("qtd_token_map: PID_W must be 8");
   end
   if (TOK_W != 2) begin : g_bad_tok
      $error("qtd_token_map: TOK_W must be 2");
   end

   logic [NIB_W-1:0] nib;
   logic             valid;

   always_comb begin
      valid = 1'b1;
      case (tok)
         TOK_OUT:   nib = NIB_W'(4'h1);
         TOK_IN:    nib = NIB_W'(4'h9);
         TOK_SETUP: nib = NIB_W'(4'hD);
         default: begin
            nib   = '0;
            valid = 1'b0;
         end
      endcase
   end

   // A PID byte is the PID nibble with its complement in the upper half.
   for (genvar i = 0; i < NIB_W; i++) begin : g_pid_bit
      assign pid[i]         = nib[i] & valid;
      assign pid[i + NIB_W] = ~nib[i] & valid;
   end

endmodule

// File: rtl/qtd_retry_ctr.sv
module qtd_retry_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             upd,
   input  logic [2:0]       code,
   input  logic             reload_ok,
   output logic [CNT_W-1:0] cnt,
   output logic             exhaust
);
   import qtd_pkg::*;

   localparam logic [CNT_W-1:0] RELOAD = '1;
   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("qtd_retry_ctr: CNT_W must be at least 1");
   end

   logic             nonzero;
   logic             dec;
   logic             rel;
   logic [CNT_W-1:0] cnt_d;

   assign nonzero = (cnt != '0);
   assign dec     = upd && (code == OUT_XERR) && nonzero;
   assign rel     = upd && (code == OUT_OK) && reload_ok && nonzero;
   assign exhaust = upd && (code == OUT_XERR) && (cnt == ONE);

   always_comb begin
      cnt_d = cnt;
      if (ld)       cnt_d = ld_val;
      else if (dec) cnt_d = cnt - ONE;
      else if (rel) cnt_d = RELOAD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end

   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cnt == '0) |=> (cnt == '0)); // R4

   AST_EXHAUST_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (exhaust && !ld) |=> (cnt == '0)); // R5

   AST_NO_DEC_ON_HALT_OR_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && upd && (code == OUT_STALL || code == OUT_BABBLE || code == OUT_BUFERR))
      |=> $stable(cnt)); // R6

endmodule

// File: rtl/qtd_flag_regs.sv
module qtd_flag_regs (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic       ld_active,
   input  logic       upd,
   input  logic       illegal_now,
   input  logic [2:0] code,
   input  logic       exhaust,
   output logic       active,
   output logic       halted,
   output logic       babble,
   output logic       buf_err,
   output logic       illegal,
   output logic       irq
);
   import qtd_pkg::*;

   localparam int N_STICKY = 2;

   logic legal_upd;
   logic halt_evt;

   assign legal_upd = upd && !illegal_now;
   assign halt_evt  = (upd && illegal_now) ||
                      (legal_upd && (code == OUT_STALL || code == OUT_BABBLE)) ||
                      exhaust;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         halted  <= 1'b0;
         illegal <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= exhaust && !ld;
         if (ld) begin
            active  <= ld_active;
            halted  <= 1'b0;
            illegal <= 1'b0;
         end else if (halt_evt) begin
            active  <= 1'b0;
            halted  <= 1'b1;
            if (upd && illegal_now) illegal <= 1'b1;
         end
      end
   end

   // Sticky flags: index 0 babble, index 1 buffer error.
   logic [N_STICKY-1:0] set_v;
   logic [N_STICKY-1:0] flag_q;

   assign set_v[0] = legal_upd && (code == OUT_BABBLE);
   assign set_v[1] = legal_upd && (code == OUT_BUFERR);

   for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q[i] <= 1'b0;
         else if (ld)       flag_q[i] <= 1'b0;
         else if (set_v[i]) flag_q[i] <= 1'b1;
      end
   end

   assign babble  = flag_q[0];
   assign buf_err = flag_q[1];

   AST_HALT_DEACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !active); // R9

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R5

   AST_BUF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_err && !ld) |=> buf_err); // R7

   AST_BABBLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      babble |-> halted || ld); // R6

endmodule

// File: rtl/qtd_status_updater.sv
module qtd_status_updater #(
   parameter int CNT_W = 2,
   parameter int TOK_W = 2,
   parameter int PID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic [CNT_W-1:0] ld_count,
   input  logic             ld_active,
   input  logic [TOK_W-1:0] ld_token,
   input  logic             ev_valid,
   input  logic [2:0]       ev_code,
   input  logic [1:0]       ep_speed,
   input  logic             async_sched,
   output logic [CNT_W-1:0] err_cnt,
   output logic             active,
   output logic             halted,
   output logic             babble,
   output logic             buf_err,
   output logic             illegal_cfg,
   output logic             err_irq,
   output logic [PID_W-1:0] pid_byte
);
   import qtd_pkg::*;

   logic [TOK_W-1:0] tok_q;
   logic             upd_en;
   logic             illegal_now;
   logic             ctr_upd;
   logic             reload_ok;
   logic             exhaust;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tok_q <= '0;
      else if (ld_valid) tok_q <= ld_token;
   end

   assign upd_en      = ev_valid && active && !ld_valid;
   assign illegal_now = (tok_q == TOK_W'(TOK_RSV)) ||
                        ((err_cnt == '0) && (ep_speed != SPD_HIGH));
   assign ctr_upd     = upd_en && !illegal_now;
   assign reload_ok   = (ep_speed == SPD_HIGH) || async_sched;

   qtd_retry_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ld_valid),
      .ld_val    (ld_count),
      .upd       (ctr_upd),
      .code      (ev_code),
      .reload_ok (reload_ok),
      .cnt       (err_cnt),
      .exhaust   (exhaust)
   );

   qtd_flag_regs flags_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld          (ld_valid),
      .ld_active   (ld_active),
      .upd         (upd_en),
      .illegal_now (illegal_now),
      .code        (ev_code),
      .exhaust     (exhaust),
      .active      (active),
      .halted      (halted),
      .babble      (babble),
      .buf_err     (buf_err),
      .illegal     (illegal_cfg),
      .irq         (err_irq)
   );

   qtd_token_map #(.TOK_W(TOK_W), .PID_W(PID_W)) map_i (
      .tok (tok_q),
      .pid (pid_byte)
   );

   AST_INACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !ld_valid)
      |=> $stable({err_cnt, halted, babble, buf_err, illegal_cfg})); // R10

   AST_IRQ_WITH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> (halted && err_cnt == '0)); // R5

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> (!halted && !babble && !buf_err && !illegal_cfg)); // R2

endmodule

// File: tb/qtd_status_updater_tb.sv
module qtd_status_updater_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_valid = 1'b0;
   logic [1:0] ld_count = '0;
   logic       ld_active = 1'b0;
   logic [1:0] ld_token = '0;
   logic       ev_valid = 1'b0;
   logic [2:0] ev_code = '0;
   logic [1:0] ep_speed = '0;
   logic       async_sched = 1'b0;
   logic [1:0] err_cnt;
   logic       active, halted, babble, buf_err, illegal_cfg, err_irq;
   logic [7:0] pid_byte;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   qtd_status_updater dut_i (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_count(ld_count),
      .ld_active(ld_active), .ld_token(ld_token), .ev_valid(ev_valid),
      .ev_code(ev_code), .ep_speed(ep_speed), .async_sched(async_sched),
      .err_cnt(err_cnt), .active(active), .halted(halted), .babble(babble),
      .buf_err(buf_err), .illegal_cfg(illegal_cfg), .err_irq(err_irq),
      .pid_byte(pid_byte)
   );

   // state vector {cnt[1:0], active, halted, babble, buf_err, illegal, irq}
   function automatic logic [7:0] state_now();
      return {err_cnt, active, halted, babble, buf_err, illegal_cfg, err_irq};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected state after loading (c, active=1, tok) and one outcome strobe.
   function automatic logic [7:0] expect_one(input logic [1:0] c, input logic [1:0] tok,
                                             input logic [1:0] spd, input logic as,
                                             input logic [2:0] code);
      logic [1:0] n = c;
      logic a = 1, h = 0, b = 0, f = 0, il = 0, q = 0;
      if (tok == 2'd3 || (c == 0 && spd != 2'b10)) begin
         a = 0; h = 1; il = 1;
      end else begin
         case (code)
            3'd0: if (c != 0 && (spd == 2'b10 || as)) n = 2'd3;
            3'd1: if (c == 1) begin n = 0; a = 0; h = 1; q = 1; end
                  else if (c != 0) n = c - 1;
            3'd2: begin a = 0; h = 1; end
            3'd3: begin a = 0; h = 1; b = 1; end
            3'd4: f = 1;
            default: ;
         endcase
      end
      return {n, a, h, b, f, il, q};
   endfunction

   function automatic string tag_of(input logic [1:0] c, input logic [1:0] tok,
                                    input logic [1:0] spd, input logic [2:0] code);
      if (tok == 2'd3 || (c == 0 && spd != 2'b10)) return "R11";
      case (code)
         3'd0: return "R8";
         3'd1: return (c == 1) ? "R5" : "R4";
         3'd2: return "R6";
         3'd3: return "R6";
         3'd4: return "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic do_load(input logic [1:0] c, input logic a, input logic [1:0] t);
      @(negedge clk);
      ld_valid = 1; ld_count = c; ld_active = a; ld_token = t;
      @(negedge clk);
      ld_valid = 0;
   endtask

   task automatic do_event(input logic [2:0] code);
      @(negedge clk);
      ev_valid = 1; ev_code = code;
      @(negedge clk);
      ev_valid = 0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state; pid for token 00 is E1h
      chk("R1", state_now(), 8'h00);
      chk("R1", pid_byte, 8'hE1);
      rst_n = 1;
      @(negedge clk);
      chk("R1", state_now(), 8'h00);

      // R3 token to PID mapping
      do_load(2'd3, 1, 2'd0); chk("R3", pid_byte, 8'hE1);
      do_load(2'd3, 1, 2'd1); chk("R3", pid_byte, 8'h69);
      do_load(2'd3, 1, 2'd2); chk("R3", pid_byte, 8'h2D);
      do_load(2'd3, 1, 2'd3); chk("R3", pid_byte, 8'h00);

      // Sweep: every counter, token, speed, schedule and outcome
      for (int c = 0; c < 4; c++)
         for (int t = 0; t < 4; t++)
            for (int s = 0; s < 4; s++)
               for (int a = 0; a < 2; a++)
                  for (int e = 0; e < 8; e++) begin
                     ep_speed = 2'(s); async_sched = 1'(a);
                     do_load(2'(c), 1, 2'(t));
                     chk("R2", state_now(), {2'(c), 6'b100000});
                     do_event(3'(e));
                     chk(tag_of(2'(c), 2'(t), 2'(s), 3'(e)), state_now(),
                         expect_one(2'(c), 2'(t), 2'(s), 1'(a), 3'(e)));
                     if (halted && active) chk("R9", 8'h1, 8'h0);
                  end

      // R5 walk to exhaustion on full speed, irq one cycle only
      ep_speed = 2'b00; async_sched = 0;
      do_load(2'd3, 1, 2'd1);
      do_event(3'd1); chk("R4", state_now(), 8'b10_100000);
      do_event(3'd1); chk("R4", state_now(), 8'b01_100000);
      do_event(3'd1); chk("R5", state_now(), 8'b00_010001);
      @(negedge clk);  chk("R5", state_now(), 8'b00_010000);
      // R10 inactive descriptor ignores strobes
      for (int e = 0; e < 8; e++) begin
         do_event(3'(e)); chk("R10", state_now(), 8'b00_010000);
      end

      // R4 unlimited retries on high speed with counter 0
      ep_speed = 2'b10;
      do_load(2'd0, 1, 2'd0);
      for (int k = 0; k < 10; k++) do_event(3'd1);
      chk("R4", state_now(), 8'b00_100000);
      do_event(3'd0); chk("R8", state_now(), 8'b00_100000);

      // R7 buffer error sticky across later outcomes
      ep_speed = 2'b00; async_sched = 1;
      do_load(2'd2, 1, 2'd1);
      do_event(3'd4); chk("R7", state_now(), 8'b10_100100);
      do_event(3'd1); chk("R7", state_now(), 8'b01_100100);
      do_event(3'd0); chk("R8", state_now(), 8'b11_100100);
      do_event(3'd4); chk("R7", state_now(), 8'b11_100100);

      // R2 load beats a same-cycle strobe
      do_load(2'd1, 1, 2'd0);
      @(negedge clk);
      ld_valid = 1; ld_count = 2'd2; ld_active = 1; ld_token = 2'd2;
      ev_valid = 1; ev_code = 3'd1;
      @(negedge clk);
      ld_valid = 0; ev_valid = 0;
      chk("R2", state_now(), 8'b10_100000);
      chk("R2", pid_byte, 8'h2D);

      // R10 loaded inactive: strobes ignored
      do_load(2'd2, 0, 2'd0);
      do_event(3'd3); chk("R10", state_now(), 8'b10_000000);
      do_event(3'd1); chk("R10", state_now(), 8'b10_000000);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule